// File: doc/BRIEF.md
# Indexed Command/Data Register Port

This block is the host-facing slave of a peripheral that shows the host only two 16-bit locations: a data port and a command port. To reach an internal register, the host first writes an index to the command port. Bit 7 of that write gives the direction: set means the data accesses that follow are writes, and clear means they are reads. Register contents then move through the data port in 16-bit pieces. Narrow registers take one data access. Wide 32-bit registers take two data accesses, low half first.

Inside the block are a small register file, a command latch and a half-word sequencer. The register file holds two 32-bit control words, two 16-bit writable words, two read-only identity words and a write-only reset key register. A 32-bit write is held in a staging register and takes effect only when its high half arrives. A 32-bit read captures the high half at the moment the low half is read. Any new command write returns the sequencer to the low half.

The host drives one-cycle strobes. `bus_addr` 0 selects the data port and 1 selects the command port. Read data is registered.

Top module: `idx_port`

## Requirements
- R1: After reset, the latched command is 0x00, the sequencer is at the low half and `bus_rdata` is 0. The writable registers hold their reset values: index 0x01 = 0x00000000, index 0x0D = 0x00002EDF, index 0x20 = 0x0028, index 0x28 = 0x0000.
- R2: A command-port write latches `bus_wdata[7:0]`. Bits 6:0 are the register index and bit 7 is the direction, with 1 meaning write. A command-port read returns {8'h00, latched command}.
- R3: Indices 0x00, 0x20, 0x27, 0x28 and 0x29 are 16-bit registers. Each is read or written with exactly one data-port access.
- R4: Indices 0x01 and 0x0D are 32-bit registers, written with two data-port writes, low half first. The register does not change until the high half is written, and then both halves change together.
- R5: A 32-bit register is read with two data-port reads, low half first. The high half returned is the value captured when the low half was read.
- R6: A command-port write always returns the sequencer to the low half, so an interrupted 32-bit transfer leaves no partial state.
- R7: Once a register access is complete, further data-port accesses without a new command act on the same register again, starting from its low half.
- R8: Index 0x00 reads 0x0011 and index 0x27 reads 0x6120. Writes to either index are ignored.
- R9: Reads of an index that has no register return 0, and writes to such an index are ignored.
- R10: Writing 0x00F6 to index 0x29 returns every writable register to its reset value. Any other value written there has no effect, and index 0x29 reads as 0.
- R11: A data-port read while the command direction is write returns 0 and does not move the sequencer. A data-port write while the command direction is read is ignored.
- R12: `bus_rdata` changes only on the clock edge that samples a read strobe. It then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | Write access; takes priority over bus_rd |
| bus_rd | input | 1 | Read access |
| bus_addr | input | 1 | 0 = data port, 1 = command port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid after the read edge |

## Verification
The hardest state to reach is a 32-bit write that has been cut off halfway. The staging register then holds a low half and the sequencer points at the high half. This state is only visible in how the next data writes are interpreted. The bench reaches it by writing a low half, issuing a fresh write command, and then sending a full pair. It reads the register back to show that the stale low half was discarded. The same partial state is also combined with a read strobe of the wrong direction between the two halves, and with a lone low-half write followed by a read command, to show that the register stays unchanged until a high half completes the pair.

// File: rtl/idx_port.sv
module idx_port #(
  parameter logic [15:0] REV_ID    = 16'h0011,
  parameter logic [15:0] CHIP_ID   = 16'h6120,
  parameter logic [31:0] CTRL_RST  = 32'h0000_0000,
  parameter logic [31:0] INTV_RST  = 32'h0000_2EDF,
  parameter logic [15:0] HWCFG_RST = 16'h0028,
  parameter logic [15:0] RESET_KEY = 16'h00F6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);

  localparam logic [6:0] IX_REV   = 7'h00;
  localparam logic [6:0] IX_CTRL  = 7'h01;
  localparam logic [6:0] IX_INTV  = 7'h0D;
  localparam logic [6:0] IX_HWCFG = 7'h20;
  localparam logic [6:0] IX_CHIP  = 7'h27;
  localparam logic [6:0] IX_SCR   = 7'h28;
  localparam logic [6:0] IX_SRST  = 7'h29;

  logic [7:0]  cmd_q;
  logic        half_q;
  logic [15:0] stage_q, snap_q;
  logic [31:0] ctrl_q, intv_q;
  logic [15:0] hwcfg_q, scr_q;
  logic [31:0] rd_val;

  wire [6:0] idx    = cmd_q[6:0];
  wire       dir_wr = cmd_q[7];
  wire cur_wide     = (idx == IX_CTRL) || (idx == IX_INTV);

  wire cmd_wr_ev = bus_sel && bus_wr && bus_addr;
  wire cmd_rd_ev = bus_sel && !bus_wr && bus_rd && bus_addr;
  wire dat_wr_ev = bus_sel && bus_wr && !bus_addr && dir_wr;
  wire dat_rd_ev = bus_sel && !bus_wr && bus_rd && !bus_addr;
  wire dat_rd_ok = dat_rd_ev && !dir_wr;

  wire        commit     = dat_wr_ev && (!cur_wide || half_q);
  wire [31:0] commit_val = cur_wide ? {bus_wdata, stage_q} : {16'h0000, bus_wdata};
  wire        soft_rst   = commit && (idx == IX_SRST) && (bus_wdata == RESET_KEY);

  always_comb begin
    case (idx)
      IX_REV:   rd_val = {16'h0000, REV_ID};
      IX_CTRL:  rd_val = ctrl_q;
      IX_INTV:  rd_val = intv_q;
      IX_HWCFG: rd_val = {16'h0000, hwcfg_q};
      IX_CHIP:  rd_val = {16'h0000, CHIP_ID};
      IX_SCR:   rd_val = {16'h0000, scr_q};
      default:  rd_val = 32'h0000_0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ctrl_q  <= CTRL_RST;
      intv_q  <= INTV_RST;
      hwcfg_q <= HWCFG_RST;
      scr_q   <= 16'h0000;
    end else if (commit) begin
      case (idx)
        IX_CTRL:  ctrl_q  <= commit_val;
        IX_INTV:  intv_q  <= commit_val;
        IX_HWCFG: hwcfg_q <= commit_val[15:0];
        IX_SCR:   scr_q   <= commit_val[15:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      half_q  <= 1'b0;
      stage_q <= 16'h0000;
      snap_q  <= 16'h0000;
    end else if (cmd_wr_ev) begin
      cmd_q  <= bus_wdata[7:0];
      half_q <= 1'b0;
    end else if (dat_wr_ev && cur_wide) begin
      if (!half_q) stage_q <= bus_wdata;
      half_q <= !half_q;
    end else if (dat_rd_ok && cur_wide) begin
      if (!half_q) snap_q <= rd_val[31:16];
      half_q <= !half_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= 16'h0000;
    else if (cmd_rd_ev)
      bus_rdata <= {8'h00, cmd_q};
    else if (dat_rd_ev)
      bus_rdata <= dir_wr ? 16'h0000 : (half_q ? snap_q : rd_val[15:0]);
  end

endmodule

// File: rtl/idx_port_chk.sv
module idx_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [7:0]  cmd_q,
  input logic        half_q,
  input logic        cur_wide,
  input logic [31:0] ctrl_q,
  input logic [31:0] intv_q,
  input logic [15:0] scr_q
);

  assert_cmd_clears_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr) |=> !half_q);

  assert_half_only_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> cur_wide);

  assert_low_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr && cmd_q[7] && cur_wide && !half_q)
      |=> ($stable(ctrl_q) && $stable(intv_q)));

  assert_key_clears_scratch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr && cmd_q == 8'hA9 && bus_wdata == 16'h00F6)
      |=> (scr_q == 16'h0000));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd && !bus_wr) |=> $stable(bus_rdata));

  assert_wrong_dir_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && !bus_wr && !bus_addr && cmd_q[7])
      |=> (bus_rdata == 16'h0000 && $stable(half_q)));

endmodule

bind idx_port idx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cmd_q(cmd_q), .half_q(half_q), .cur_wide(cur_wide),
  .ctrl_q(ctrl_q), .intv_q(intv_q), .scr_q(scr_q)
);

// File: tb/tb_idx_port.sv
module tb_idx_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idx_port dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);  access(1'b1, 1'b1, {8'h00, c}); endtask
  task automatic wdat(input logic [15:0] d); access(1'b1, 1'b0, d); endtask
  task automatic rdat(output logic [15:0] v); access(1'b0, 1'b0, 16'h0); v = bus_rdata; endtask
  task automatic rcmd(output logic [15:0] v); access(1'b0, 1'b1, 16'h0); v = bus_rdata; endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    rcmd(v); check("R1 command after reset", v, 16'h0000);
    rdat(v); check("R8 revision", v, 16'h0011);
    cmd(8'h0D); rdat(v); check("R1 interval low", v, 16'h2EDF);
    rdat(v); check("R1 interval high", v, 16'h0000);
    cmd(8'h20); rdat(v); check("R1 hwcfg", v, 16'h0028);
  endtask

  task automatic t_narrow;
    logic [15:0] v;
    cmd(8'hA8); rcmd(v); check("R2 command readback", v, 16'h00A8);
    wdat(16'h1234);
    cmd(8'h28); check("R12 rdata held over command write", bus_rdata, 16'h00A8);
    rdat(v); check("R3 scratch read", v, 16'h1234);
    repeat (3) @(negedge clk);
    check("R12 rdata held while idle", bus_rdata, 16'h1234);
    rdat(v); check("R7 narrow repeat", v, 16'h1234);
    cmd(8'hA0); wdat(16'h0055); cmd(8'h20); rdat(v); check("R3 hwcfg write", v, 16'h0055);
  endtask

  task automatic t_wide;
    logic [15:0] v;
    cmd(8'h81); wdat(16'h5678);
    cmd(8'h01); rdat(v); check("R4 low half alone no commit (lo)", v, 16'h0000);
    rdat(v); check("R4 low half alone no commit (hi)", v, 16'h0000);
    cmd(8'h81); wdat(16'h5678); wdat(16'h9ABC);
    cmd(8'h01); rdat(v); check("R5 wide read low", v, 16'h5678);
    rdat(v); check("R5 wide read high", v, 16'h9ABC);
    rdat(v); check("R7 wide repeat from low", v, 16'h5678);
  endtask

  task automatic t_abort;
    logic [15:0] v;
    cmd(8'h8D); wdat(16'h1111);
    cmd(8'h8D); wdat(16'h2222); wdat(16'h3333);
    cmd(8'h0D); rdat(v); check("R6 restart low", v, 16'h2222);
    rdat(v); check("R6 restart high", v, 16'h3333);
  endtask

  task automatic t_readonly_unmapped;
    logic [15:0] v;
    cmd(8'hA7); wdat(16'hFFFF); cmd(8'h27); rdat(v); check("R8 chip id write ignored", v, 16'h6120);
    cmd(8'h80); wdat(16'h0000); cmd(8'h00); rdat(v); check("R8 revision write ignored", v, 16'h0011);
    cmd(8'h85); wdat(16'hBEEF); cmd(8'h05); rdat(v); check("R9 unmapped read", v, 16'h0000);
    cmd(8'h7F); rdat(v); check("R9 top index read", v, 16'h0000);
  endtask

  task automatic t_mismatch;
    logic [15:0] v;
    cmd(8'h81); wdat(16'h0001);
    rdat(v); check("R11 read under write command", v, 16'h0000);
    wdat(16'h0002);
    cmd(8'h01); rdat(v); check("R11 sequencer kept (lo)", v, 16'h0001);
    rdat(v); check("R11 sequencer kept (hi)", v, 16'h0002);
    cmd(8'hA8); wdat(16'h4444);
    cmd(8'h28); wdat(16'h7777); rdat(v); check("R11 write under read command", v, 16'h4444);
  endtask

  task automatic t_softreset;
    logic [15:0] v;
    cmd(8'hA9); wdat(16'h00F5);
    cmd(8'h28); rdat(v); check("R10 wrong key no effect", v, 16'h4444);
    cmd(8'h29); rdat(v); check("R10 reset register reads zero", v, 16'h0000);
    cmd(8'hA9); wdat(16'h00F6);
    cmd(8'h28); rdat(v); check("R10 scratch restored", v, 16'h0000);
    cmd(8'h01); rdat(v); check("R10 ctrl lo restored", v, 16'h0000);
    rdat(v); check("R10 ctrl hi restored", v, 16'h0000);
    cmd(8'h0D); rdat(v); check("R10 interval lo restored", v, 16'h2EDF);
    rdat(v); check("R10 interval hi restored", v, 16'h0000);
    cmd(8'h20); rdat(v); check("R10 hwcfg restored", v, 16'h0028);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_abort();
    t_readonly_unmapped();
    t_mismatch();
    t_softreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule